// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that lives in memory. A requester hands it a virtual address together with the base of the top-level (root) table. The walker then makes two word reads on a single-outstanding memory port. The first read fetches the top-level entry, which names the second-level table. The second read fetches the leaf entry, which names the physical frame. The block returns either the translated address or a fault.

Pages are 4 KB, so the low 12 bits of the virtual address become the low 12 bits of the physical address unchanged. The 20-bit page number has two parts: the upper 10 bits index the root table and the lower 10 bits index the second-level table. Each entry is 4 bytes. Bit 0 of an entry is its valid flag and bits 31:12 hold a page-aligned base (a table base for a top-level entry, a frame number for a leaf entry).

All three data paths use valid/ready handshakes. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. A memory read is issued in a cycle where `mem_req_valid` and `mem_req_ready` are both high. While `mem_req_ready` is low the walker holds the request and its address unchanged. The memory answers later with a one-cycle `mem_rsp_valid` pulse, after any number of cycles, and never in the same cycle the read is accepted. A result stays on `res_*` until it is taken with `res_ready`. The walker takes no new request until the result has been consumed.

Top module: `pt_walker2`

## Requirements
- R1: During reset and in the first cycle after it, `req_ready` is 1 and `mem_req_valid` and `res_valid` are 0. A reset in the middle of a walk drops that walk.
- R2: The cycle after a request is accepted, `mem_req_valid` is 1 with `mem_req_addr` = {root[31:12], 12'h000} + 4 × vaddr[31:22]. The low 12 bits of the root input are ignored.
- R3: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and `mem_req_addr` does not change. A `mem_rsp_valid` pulse in that period is ignored.
- R4: When the top-level entry has bit 0 = 1, the cycle after its response `mem_req_valid` is 1 with `mem_req_addr` = {entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R5: When the top-level entry has bit 0 = 0, the cycle after its response the walker shows `res_valid` = 1, `res_fault` = 1 and `res_paddr` = 0, and it issues no second read.
- R6: When the leaf entry has bit 0 = 0, the cycle after its response the walker shows `res_valid` = 1, `res_fault` = 1 and `res_paddr` = 0.
- R7: When both entries are valid, the cycle after the leaf response the walker shows `res_valid` = 1, `res_fault` = 0 and `res_paddr` = {leaf[31:12], vaddr[11:0]}.
- R8: From the acceptance of a request until its result is taken, `req_ready` is 0. After a read is accepted, `mem_req_valid` stays 0 until that read's response arrives. A `mem_rsp_valid` pulse while no read is pending has no effect.
- R9: While `res_valid` is 1 and `res_ready` is 0, the result fields hold steady. The cycle after `res_ready` is seen, `res_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Root table base; bits 11:0 ignored |
| mem_req_valid | output | 1 | Memory word read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present (one-cycle pulse) |
| mem_rsp_data | input | 32 | Entry word read from memory |
| res_valid | output | 1 | Translation result present |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address, 0 on fault |
| res_fault | output | 1 | Walk ended on an invalid entry |

## Verification
Most faults in the walk state show up at the ports within one cycle. A walker stuck in a read state keeps `req_ready` low and never raises `res_valid`. A lost "read pending" flag shows up as a second `mem_req_valid` right after a read is accepted, or as an early response being taken. A wrong table base or a swapped index field shows up as a wrong `mem_req_addr` on the second read, or as a wrong frame in `res_paddr`, in the cycle that read or result first appears. A fault path that falls through to the second level shows up as an extra memory request in the cycle after an invalid top-level entry returns.

// File: rtl/ptw2_pkg.sv
package ptw2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OUTER = 3'd1,
    ST_INNER = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_state_e;
endpackage

// File: rtl/ptw2_addr_gen.sv
// Forms the byte address of the entry to read, at either level.
module ptw2_addr_gen #(
  parameter int VA_W      = 32,
  parameter int PG_SHIFT  = 12,
  parameter int OUT_IDX_W = 10,
  parameter int PTE_SHIFT = 2
) (
  input  logic [VA_W-PG_SHIFT-1:0] root_base,
  input  logic [VA_W-PG_SHIFT-1:0] tbl_base,
  input  logic [VA_W-PG_SHIFT-1:0] vpn,
  input  logic                     sel_inner,
  output logic [VA_W-1:0]          entry_addr
);
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int IN_IDX_W = VPN_W - OUT_IDX_W;

  logic [OUT_IDX_W-1:0] out_idx;
  logic [IN_IDX_W-1:0]  in_idx;
  logic [VPN_W-1:0]     base;
  logic [VA_W-1:0]      idx_off;

  always_comb begin
    out_idx = vpn[VPN_W-1 -: OUT_IDX_W];
    in_idx  = vpn[IN_IDX_W-1:0];
    base    = sel_inner ? tbl_base : root_base;
    if (sel_inner) idx_off = VA_W'(in_idx)  << PTE_SHIFT;
    else           idx_off = VA_W'(out_idx) << PTE_SHIFT;
    entry_addr = {base, {PG_SHIFT{1'b0}}} + idx_off;
  end
endmodule

// File: rtl/ptw2_walk_ctrl.sv
// Walk sequencing: request intake, ordered reads, response capture, result.
module ptw2_walk_ctrl
  import ptw2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic mem_req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic entry_ok,
  output logic res_valid,
  input  logic res_ready,
  output logic res_fault,
  output logic cap_req,
  output logic cap_tbl,
  output logic cap_frame,
  output logic sel_inner
);
  walk_state_e st_q, st_d;
  logic pend_q, pend_d;
  logic reading, rsp_take;

  always_comb begin
    reading       = (st_q == ST_OUTER) || (st_q == ST_INNER);
    req_ready     = (st_q == ST_IDLE);
    mem_req_valid = reading && !pend_q;
    sel_inner     = (st_q == ST_INNER);
    res_valid     = (st_q == ST_DONE) || (st_q == ST_FAULT);
    res_fault     = (st_q == ST_FAULT);
    cap_req       = req_valid && req_ready;
    rsp_take      = reading && pend_q && mem_rsp_valid;
    cap_tbl       = rsp_take && (st_q == ST_OUTER) && entry_ok;
    cap_frame     = rsp_take && (st_q == ST_INNER) && entry_ok;
  end

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    unique case (st_q)
      ST_IDLE: if (cap_req) begin
        st_d   = ST_OUTER;
        pend_d = 1'b0;
      end
      ST_OUTER, ST_INNER: begin
        if (mem_req_valid && mem_req_ready) pend_d = 1'b1;
        if (rsp_take) begin
          pend_d = 1'b0;
          if (!entry_ok)           st_d = ST_FAULT;
          else if (st_q == ST_OUTER) st_d = ST_INNER;
          else                     st_d = ST_DONE;
        end
      end
      ST_DONE, ST_FAULT: if (res_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/pt_walker2.sv
module pt_walker2 #(
  parameter int VA_W      = 32,
  parameter int PG_SHIFT  = 12,
  parameter int OUT_IDX_W = 10,
  parameter int PTE_SHIFT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [VA_W-1:0] req_root,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [VA_W-1:0] res_paddr,
  output logic            res_fault
);
  localparam int BASE_W = VA_W - PG_SHIFT;

  logic [VA_W-1:0]   va_q;
  logic [BASE_W-1:0] root_q, tbl_q, frame_q;
  logic cap_req, cap_tbl, cap_frame, sel_inner;

  ptw2_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .entry_ok      (mem_rsp_data[0]),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_fault     (res_fault),
    .cap_req       (cap_req),
    .cap_tbl       (cap_tbl),
    .cap_frame     (cap_frame),
    .sel_inner     (sel_inner)
  );

  ptw2_addr_gen #(
    .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .OUT_IDX_W(OUT_IDX_W), .PTE_SHIFT(PTE_SHIFT)
  ) u_agen (
    .root_base  (root_q),
    .tbl_base   (tbl_q),
    .vpn        (va_q[VA_W-1:PG_SHIFT]),
    .sel_inner  (sel_inner),
    .entry_addr (mem_req_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q    <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      frame_q <= '0;
    end else begin
      if (cap_req) begin
        va_q   <= req_vaddr;
        root_q <= req_root[VA_W-1:PG_SHIFT];
      end
      if (cap_tbl)   tbl_q   <= mem_rsp_data[VA_W-1:PG_SHIFT];
      if (cap_frame) frame_q <= mem_rsp_data[VA_W-1:PG_SHIFT];
    end
  end

  always_comb begin
    if (res_valid && !res_fault) res_paddr = {frame_q, va_q[PG_SHIFT-1:0]};
    else                         res_paddr = '0;
  end
endmodule

// File: rtl/pt_walker2_chk.sv
module pt_walker2_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_paddr,
  input logic        res_fault
);
  a_r3_mreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r8_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  a_r8_busy_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || res_valid) |-> !req_ready);

  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_paddr == 32'h0);

  a_r5_no_read_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid);

  a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) && $stable(res_fault));

  a_r9_res_release: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid && req_ready);
endmodule

bind pt_walker2 pt_walker2_chk u_chk (.*);

// File: tb/pt_walker2_tb_top.sv
module pt_walker2_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // vaddr, root, top-level entry, leaf entry, response latency, ready stall
  localparam logic [31:0] V_VA  [NV] = '{32'h0040_3ABC, 32'hFFFF_FFFF, 32'h0000_0000,
                                         32'h1234_5678, 32'h0ABC_DEF0, 32'hFFC0_0000};
  localparam logic [31:0] V_RT  [NV] = '{32'h0010_0000, 32'h8000_0FFF, 32'h0000_0000,
                                         32'h0002_0000, 32'h0003_0123, 32'h0000_5000};
  localparam logic [31:0] V_OE  [NV] = '{32'h0020_0001, 32'h1234_5FFF, 32'h0000_1001,
                                         32'hFFFF_FFFE, 32'h0030_0001, 32'h7FFF_F001};
  localparam logic [31:0] V_IE  [NV] = '{32'h0ABC_D001, 32'hFFFF_F001, 32'h0000_0003,
                                         32'h5555_5001, 32'hABCD_E000, 32'h4444_4FFF};
  localparam int V_LAT [NV] = '{0, 3, 1, 2, 2, 4};
  localparam int V_STL [NV] = '{0, 2, 0, 1, 1, 3};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0, req_root = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid, res_ready = 1'b0, res_fault;
  logic [31:0] res_paddr;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker2 dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Serve one read that is already being requested at the current negedge.
  task automatic serve_read(input logic [31:0] exp_addr, input logic [31:0] data,
                            input int lat, input int stall, input bit spur);
    for (int i = 0; i < stall; i++) begin
      if (spur && i == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = 32'hDEAD_BEE1; end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R3 request held", {31'b0, mem_req_valid}, 32'd1);
      chk("R3 address held", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R8 single read pending", {31'b0, mem_req_valid}, 32'd0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R8 no request while waiting", {31'b0, mem_req_valid}, 32'd0);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
  endtask

  task automatic run_walk(input logic [31:0] va, input logic [31:0] root,
                          input logic [31:0] oent, input logic [31:0] ient,
                          input int lat, input int stall, input int rdel, input bit spur);
    logic [31:0] exp_oa, exp_ia, exp_pa;
    logic        exp_f;
    exp_oa = {root[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
    exp_ia = {oent[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    exp_f  = !oent[0] || !ient[0];
    exp_pa = exp_f ? 32'h0 : {ient[31:12], va[11:0]};
    chk("R9 ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_root = root;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = ~va; req_root = ~root;
    chk("R8 busy after intake", {31'b0, req_ready}, 32'd0);
    chk("R2 outer request", {31'b0, mem_req_valid}, 32'd1);
    chk("R2 outer address", mem_req_addr, exp_oa);
    serve_read(exp_oa, oent, lat, stall, spur);
    if (!oent[0]) begin
      chk("R5 no second read", {31'b0, mem_req_valid}, 32'd0);
      chk("R5 fault flag", {31'b0, res_fault}, 32'd1);
    end else begin
      chk("R4 inner request", {31'b0, mem_req_valid}, 32'd1);
      chk("R4 inner address", mem_req_addr, exp_ia);
      serve_read(exp_ia, ient, lat, stall, 1'b0);
      chk(exp_f ? "R6 fault flag" : "R7 fault flag", {31'b0, res_fault}, {31'b0, exp_f});
    end
    chk("R7 result valid", {31'b0, res_valid}, 32'd1);
    chk(exp_f ? "R6 paddr zero" : "R7 paddr", res_paddr, exp_pa);
    for (int i = 0; i < rdel; i++) begin
      @(negedge clk);
      chk("R9 result held", res_paddr, exp_pa);
      chk("R9 valid held", {31'b0, res_valid}, 32'd1);
      chk("R8 no intake while result", {31'b0, req_ready}, 32'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R9 result released", {31'b0, res_valid}, 32'd0);
    chk("R9 ready after release", {31'b0, req_ready}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R1 no read in reset", {31'b0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no result after reset", {31'b0, res_valid}, 32'd0);
    chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);

    for (int v = 0; v < NV; v++)
      run_walk(V_VA[v], V_RT[v], V_OE[v], V_IE[v], V_LAT[v], V_STL[v], v % 3, 1'b0);

    // R8: stray response while idle has no effect
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FFFF;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R8 stray rsp idle ready", {31'b0, req_ready}, 32'd1);
    chk("R8 stray rsp idle no result", {31'b0, res_valid}, 32'd0);
    chk("R8 stray rsp idle no read", {31'b0, mem_req_valid}, 32'd0);

    // R3: response before acceptance is ignored
    run_walk(32'h8020_1FFF, 32'h0040_0000, 32'h0066_6001, 32'h0077_7001, 1, 2, 1, 1'b1);

    // R1: reset in mid-walk drops the walk
    req_valid = 1'b1; req_vaddr = 32'h1111_1111; req_root = 32'h0009_0000;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mid-walk reset ready", {31'b0, req_ready}, 32'd1);
    chk("R1 mid-walk reset no read", {31'b0, mem_req_valid}, 32'd0);
    chk("R1 mid-walk reset no result", {31'b0, res_valid}, 32'd0);

    run_walk(32'h0000_0FFF, 32'h0000_1000, 32'h0000_2001, 32'h0000_3001, 0, 0, 0, 1'b0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule